// File: doc/BRIEF.md
# Power Domain Request Sequencer

This block carries out one complete power-up or power-down request for a single numbered power domain. It does so by driving the register handshake that a power controller expects. A requester supplies a one-cycle start pulse together with a direction flag, the base offset of the domain's channel registers, the domain's bit index inside those registers, and the bit index of the domain's completion interrupt. The engine then works through the whole handshake on a simple register master port. It pulses done with a result code of ok, not-ready or I/O failure.

The handshake runs in a fixed order. First the engine optionally raises an external-request mask. It then arms the completion interrupt so that the source is enabled but masked, and clears any stale status. Next it waits for the controller to report readiness and submits the request. A rejected submission is retried a bounded number of times. The engine then waits for the completion flag and clears it. Every wait is bounded, and consecutive polls are spaced by a programmable delay. The external mask is dropped on every exit path, including early failures.

Top module: `pwr_req_seq`

## Requirements
- R1: After reset, and whenever no command is running, busy_o, done_o and bus_req_o are low.
- R2: When ext_mask_i is nonzero at start, that value is first written to address MASK_ADDR, and the final bus write of the command writes zero there on every exit path. When ext_mask_i is zero, MASK_ADDR is never accessed.
- R3: Before any submission, the engine reads the mask register (0x10) and writes it back with bit irq_idx_i set. It then does the same for the enable register (0x0C). It then writes the one-hot word 1<<irq_idx_i to the clear register (0x08).
- R4: Before each submission, the global status register (0x00) is read until bit 1 (power-on) or bit 0 (power-off) is set. If RDY_LIMIT reads all fail, the command ends with err_o = 01 and no submission is made.
- R5: A submission writes the one-hot word 1<<chan_idx_i to chan_base_i+0x0C for power-on or to chan_base_i+0x04 for power-off.
- R6: After each submission, the channel error register (chan_base_i+0x14) is read. If bit chan_idx_i is set, the engine waits, polls readiness again and resubmits. After RETRY_LIMIT rejected submissions, the command ends with err_o = 10, with neither a completion poll nor a second clear.
- R7: After an accepted submission, the interrupt status register (0x04) is read until bit irq_idx_i is set, for at most CMP_LIMIT reads. A timeout gives err_o = 10, and success gives err_o = 00. In both cases 1<<irq_idx_i is then written to 0x08.
- R8: Two consecutive polls of the same register are at least DELAY_CYCLES clock cycles apart.
- R9: busy_o rises the cycle after an accepted start and stays high through the single-cycle done_o pulse. err_o is valid with done_o and is never 11. A start pulse while busy_o is high has no effect.
- R10: bus_req_o, together with its address, write flag and write data, stays stable until bus_ack_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle command pulse |
| on_i | input | 1 | 1 = power-on, 0 = power-off |
| chan_base_i | input | ADDR_W | Base address of the domain's channel registers |
| chan_idx_i | input | $clog2(DATA_W) | Domain bit inside the channel registers |
| irq_idx_i | input | $clog2(DATA_W) | Domain bit inside the interrupt registers |
| ext_mask_i | input | DATA_W | External-request mask word, 0 = unused |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | 00 ok, 01 not ready, 10 I/O failure |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Register address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_ack_i | input | 1 | Access complete, one cycle |
| bus_rdata_i | input | DATA_W | Read data, valid with bus_ack_i |

## Verification
The register model behind the bench varies four things: how many readiness reads fail, which readiness bit is offered, how many submissions are rejected, and how many completion reads come back empty. Each variation leads to a different exit path. A clean power-on with a mask shows the full write order and the read-modify-write values. A power-off at channel bit 31 with delayed readiness shows the shutoff address, the status bit chosen and the poll spacing. Offering only the wrong readiness bit separates the not-ready path from the other exits. Rejected submissions, an endless rejection and a completion timeout separate a recovered retry from an exhausted one and show which of them still clears status. The read words set every other bit, so a design that tests the wrong bit is caught.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    // global register offsets
    localparam logic [7:0] OFS_GSTAT = 8'h00;
    localparam logic [7:0] OFS_ISTAT = 8'h04;
    localparam logic [7:0] OFS_ICLR  = 8'h08;
    localparam logic [7:0] OFS_IEN   = 8'h0C;
    localparam logic [7:0] OFS_IMSK  = 8'h10;

    // per-channel offsets from the channel base
    localparam logic [7:0] OFS_CSHUT = 8'h04;
    localparam logic [7:0] OFS_CRES  = 8'h0C;
    localparam logic [7:0] OFS_CERR  = 8'h14;

    typedef enum logic [1:0] {
        ERR_OK   = 2'b00,
        ERR_NRDY = 2'b01,
        ERR_IO   = 2'b10
    } err_e;

    typedef enum logic [4:0] {
        S_IDLE, S_MSK_SET, S_IMR_RD, S_IMR_WR, S_IER_RD, S_IER_WR,
        S_CLR_PRE, S_RDY_RD, S_RDY_WAIT, S_SUBMIT, S_ERR_RD,
        S_RETRY_WAIT, S_CMP_RD, S_CMP_WAIT, S_CLR_POST, S_MSK_CLR, S_DONE
    } state_e;

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int DELAY_CYCLES = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic fire_o
);
    localparam int CNT_W = $clog2(DELAY_CYCLES + 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (go_i) begin
            tmr_d.active = 1'b1;
            tmr_d.cnt    = CNT_W'(DELAY_CYCLES - 1);
        end else if (tmr_q.active) begin
            if (tmr_q.cnt == '0) tmr_d.active = 1'b0;
            else                 tmr_d.cnt    = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign fire_o = tmr_q.active && (tmr_q.cnt == '0);

endmodule

// File: rtl/pwr_seq_ctl.sv
module pwr_seq_ctl
    import pwr_seq_pkg::*;
#(
    parameter int              ADDR_W      = 16,
    parameter int              DATA_W      = 32,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 'h80,
    parameter int              RDY_LIMIT   = 100,
    parameter int              RETRY_LIMIT = 100,
    parameter int              CMP_LIMIT   = 1000,
    localparam int             IDX_W       = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              on_i,
    input  logic [ADDR_W-1:0] chan_base_i,
    input  logic [IDX_W-1:0]  chan_idx_i,
    input  logic [IDX_W-1:0]  irq_idx_i,
    input  logic [DATA_W-1:0] ext_mask_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        err_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              tmr_go_o,
    input  logic              tmr_fire_i
);
    localparam int POLL_MAX = (RDY_LIMIT > CMP_LIMIT) ? RDY_LIMIT : CMP_LIMIT;
    localparam int POLL_W   = $clog2(POLL_MAX + 1);
    localparam int TRY_W    = $clog2(RETRY_LIMIT + 1);

    typedef struct packed {
        state_e            st;
        logic              on;
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  chan;
        logic [IDX_W-1:0]  irq;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] rd;
        logic [POLL_W-1:0] poll;
        logic [TRY_W-1:0]  tries;
        err_e              err;
    } ctx_t;

    ctx_t ctx_d, ctx_q;
    state_e exit_st;
    logic [DATA_W-1:0] irq_bit, chan_bit;

    assign exit_st  = (ctx_q.mask != '0) ? S_MSK_CLR : S_DONE;
    assign irq_bit  = DATA_W'(1) << ctx_q.irq;
    assign chan_bit = DATA_W'(1) << ctx_q.chan;

    always_comb begin
        ctx_d    = ctx_q;
        tmr_go_o = 1'b0;
        unique case (ctx_q.st)
            S_IDLE: if (start_i) begin
                ctx_d.on    = on_i;
                ctx_d.base  = chan_base_i;
                ctx_d.chan  = chan_idx_i;
                ctx_d.irq   = irq_idx_i;
                ctx_d.mask  = ext_mask_i;
                ctx_d.tries = '0;
                ctx_d.err   = ERR_OK;
                ctx_d.st    = (ext_mask_i != '0) ? S_MSK_SET : S_IMR_RD;
            end
            S_MSK_SET: if (bus_ack_i) ctx_d.st = S_IMR_RD;
            S_IMR_RD: if (bus_ack_i) begin
                ctx_d.rd = bus_rdata_i;
                ctx_d.st = S_IMR_WR;
            end
            S_IMR_WR: if (bus_ack_i) ctx_d.st = S_IER_RD;
            S_IER_RD: if (bus_ack_i) begin
                ctx_d.rd = bus_rdata_i;
                ctx_d.st = S_IER_WR;
            end
            S_IER_WR: if (bus_ack_i) ctx_d.st = S_CLR_PRE;
            S_CLR_PRE: if (bus_ack_i) begin
                ctx_d.poll = '0;
                ctx_d.st   = S_RDY_RD;
            end
            S_RDY_RD: if (bus_ack_i) begin
                if (ctx_q.on ? bus_rdata_i[1] : bus_rdata_i[0]) begin
                    ctx_d.st = S_SUBMIT;
                end else if (ctx_q.poll == POLL_W'(RDY_LIMIT - 1)) begin
                    ctx_d.err = ERR_NRDY;
                    ctx_d.st  = exit_st;
                end else begin
                    ctx_d.poll = ctx_q.poll + 1'b1;
                    ctx_d.st   = S_RDY_WAIT;
                    tmr_go_o   = 1'b1;
                end
            end
            S_RDY_WAIT: if (tmr_fire_i) ctx_d.st = S_RDY_RD;
            S_SUBMIT: if (bus_ack_i) ctx_d.st = S_ERR_RD;
            S_ERR_RD: if (bus_ack_i) begin
                if (!bus_rdata_i[ctx_q.chan]) begin
                    ctx_d.poll = '0;
                    ctx_d.st   = S_CMP_RD;
                end else if (ctx_q.tries == TRY_W'(RETRY_LIMIT - 1)) begin
                    ctx_d.err = ERR_IO;
                    ctx_d.st  = exit_st;
                end else begin
                    ctx_d.tries = ctx_q.tries + 1'b1;
                    ctx_d.st    = S_RETRY_WAIT;
                    tmr_go_o    = 1'b1;
                end
            end
            S_RETRY_WAIT: if (tmr_fire_i) begin
                ctx_d.poll = '0;
                ctx_d.st   = S_RDY_RD;
            end
            S_CMP_RD: if (bus_ack_i) begin
                if (bus_rdata_i[ctx_q.irq]) begin
                    ctx_d.st = S_CLR_POST;
                end else if (ctx_q.poll == POLL_W'(CMP_LIMIT - 1)) begin
                    ctx_d.err = ERR_IO;
                    ctx_d.st  = S_CLR_POST;
                end else begin
                    ctx_d.poll = ctx_q.poll + 1'b1;
                    ctx_d.st   = S_CMP_WAIT;
                    tmr_go_o   = 1'b1;
                end
            end
            S_CMP_WAIT: if (tmr_fire_i) ctx_d.st = S_CMP_RD;
            S_CLR_POST: if (bus_ack_i) ctx_d.st = exit_st;
            S_MSK_CLR:  if (bus_ack_i) ctx_d.st = S_DONE;
            S_DONE:     ctx_d.st = S_IDLE;
            default:    ctx_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    // bus port decode from the registered state
    always_comb begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b0;
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        unique case (ctx_q.st)
            S_MSK_SET:  begin bus_we_o = 1'b1; bus_addr_o = MASK_ADDR; bus_wdata_o = ctx_q.mask; end
            S_IMR_RD:   bus_addr_o = ADDR_W'(OFS_IMSK);
            S_IMR_WR:   begin bus_we_o = 1'b1; bus_addr_o = ADDR_W'(OFS_IMSK); bus_wdata_o = ctx_q.rd | irq_bit; end
            S_IER_RD:   bus_addr_o = ADDR_W'(OFS_IEN);
            S_IER_WR:   begin bus_we_o = 1'b1; bus_addr_o = ADDR_W'(OFS_IEN); bus_wdata_o = ctx_q.rd | irq_bit; end
            S_CLR_PRE,
            S_CLR_POST: begin bus_we_o = 1'b1; bus_addr_o = ADDR_W'(OFS_ICLR); bus_wdata_o = irq_bit; end
            S_RDY_RD:   bus_addr_o = ADDR_W'(OFS_GSTAT);
            S_SUBMIT:   begin
                bus_we_o    = 1'b1;
                bus_addr_o  = ctx_q.base + ADDR_W'(ctx_q.on ? OFS_CRES : OFS_CSHUT);
                bus_wdata_o = chan_bit;
            end
            S_ERR_RD:   bus_addr_o = ctx_q.base + ADDR_W'(OFS_CERR);
            S_CMP_RD:   bus_addr_o = ADDR_W'(OFS_ISTAT);
            S_MSK_CLR:  begin bus_we_o = 1'b1; bus_addr_o = MASK_ADDR; end
            default:    bus_req_o = 1'b0;
        endcase
    end

    assign busy_o = (ctx_q.st != S_IDLE);
    assign done_o = (ctx_q.st == S_DONE);
    assign err_o  = ctx_q.err;

endmodule

// File: rtl/pwr_req_seq.sv
module pwr_req_seq #(
    parameter int                ADDR_W       = 16,
    parameter int                DATA_W       = 32,
    parameter logic [ADDR_W-1:0] MASK_ADDR    = 'h80,
    parameter int                DELAY_CYCLES = 125,
    parameter int                RDY_LIMIT    = 100,
    parameter int                RETRY_LIMIT  = 100,
    parameter int                CMP_LIMIT    = 1000,
    localparam int               IDX_W        = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              on_i,
    input  logic [ADDR_W-1:0] chan_base_i,
    input  logic [IDX_W-1:0]  chan_idx_i,
    input  logic [IDX_W-1:0]  irq_idx_i,
    input  logic [DATA_W-1:0] ext_mask_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        err_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [DATA_W-1:0] bus_rdata_i
);
    logic tmr_go, tmr_fire;

    pwr_seq_ctl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_ADDR(MASK_ADDR),
        .RDY_LIMIT(RDY_LIMIT), .RETRY_LIMIT(RETRY_LIMIT), .CMP_LIMIT(CMP_LIMIT)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_i), .on_i(on_i), .chan_base_i(chan_base_i),
        .chan_idx_i(chan_idx_i), .irq_idx_i(irq_idx_i), .ext_mask_i(ext_mask_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i),
        .tmr_go_o(tmr_go), .tmr_fire_i(tmr_fire)
    );

    pwr_seq_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .go_i(tmr_go), .fire_o(tmr_fire)
    );

endmodule

// File: rtl/pwr_req_seq_chk.sv
module pwr_req_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [1:0]        err_o,
    input logic              bus_req_o,
    input logic              bus_we_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [DATA_W-1:0] bus_wdata_o,
    input logic              bus_ack_i
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !bus_req_o);

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o)
                                    && $stable(bus_we_o) && $stable(bus_wdata_o));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    p_err_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> err_o != 2'b11);

    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o);

endmodule

bind pwr_req_seq pwr_req_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i)
);

// File: tb/test_pwr_req_seq.sv
module test_pwr_req_seq;
    localparam int DLY = 3;
    localparam int RDY = 6;
    localparam int RTR = 4;
    localparam int CMP = 10;
    localparam logic [15:0] MADDR = 16'h0080;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, on = 1'b0;
    logic [15:0] base = 16'h0040;
    logic [4:0]  chan = '0, irq = '0;
    logic [31:0] mval = '0;
    logic busy, done;
    logic [1:0] err;
    logic bus_req, bus_we, ack;
    logic [15:0] addr;
    logic [31:0] wdata, rdata;

    always #4 clk = ~clk;

    pwr_req_seq #(
        .ADDR_W(16), .DATA_W(32), .MASK_ADDR(MADDR), .DELAY_CYCLES(DLY),
        .RDY_LIMIT(RDY), .RETRY_LIMIT(RTR), .CMP_LIMIT(CMP)
    ) i_pwr_req_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .on_i(on), .chan_base_i(base),
        .chan_idx_i(chan), .irq_idx_i(irq), .ext_mask_i(mval),
        .busy_o(busy), .done_o(done), .err_o(err),
        .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(addr),
        .bus_wdata_o(wdata), .bus_ack_i(ack), .bus_rdata_i(rdata)
    );

    // register model configuration (driven by tasks only)
    int cfg_rdy = 0, cfg_errs = 0, cfg_cmp = 0;
    logic [31:0] cfg_word = 32'h2;

    // model state (driven by the model only)
    int cyc = 0, nw = 0, c_stat = 0, c_err = 0, c_isr = 0, last_stat = -1, min_gap = 1000000;
    logic [15:0] wl_a [0:255];
    logic [31:0] wl_d [0:255];
    logic [31:0] imr, ier;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            ack   <= 1'b0;
            rdata <= '0;
            imr = 32'h0000_0101;
            ier = 32'h0000_0010;
        end else begin
            ack <= 1'b0;
            if (start && !busy) begin
                c_stat = 0; c_err = 0; c_isr = 0; last_stat = -1; min_gap = 1000000;
            end
            if (bus_req && !ack) begin
                ack <= 1'b1;
                if (bus_we) begin
                    wl_a[nw % 256] = addr;
                    wl_d[nw % 256] = wdata;
                    nw = nw + 1;
                    if (addr == 16'h0010) imr = wdata;
                    if (addr == 16'h000C) ier = wdata;
                end else if (addr == 16'h0000) begin
                    rdata <= (c_stat < cfg_rdy) ? 32'h0 : cfg_word;
                    if (last_stat >= 0 && cyc - last_stat < min_gap) min_gap = cyc - last_stat;
                    last_stat = cyc;
                    c_stat = c_stat + 1;
                end else if (addr == 16'h0004) begin
                    rdata <= (c_isr < cfg_cmp) ? ~(32'h1 << irq) : (32'h1 << irq);
                    c_isr = c_isr + 1;
                end else if (addr == 16'h0010) begin
                    rdata <= imr;
                end else if (addr == 16'h000C) begin
                    rdata <= ier;
                end else if (addr == base + 16'h0014) begin
                    rdata <= (c_err < cfg_errs) ? ((32'h1 << chan) | 32'h0000_0001)
                                                : (32'hFFFF_FFFE & ~(32'h1 << chan));
                    c_err = c_err + 1;
                end else begin
                    rdata <= 32'hDEAD_BEEF;
                end
            end
        end
    end

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input longint act, input longint exp);
        chk(act == exp, tag, act, exp);
    endtask

    function automatic int count_to(input int w0, input logic [15:0] a);
        int n = 0;
        for (int k = w0; k < nw; k++) if (wl_a[k % 256] == a) n++;
        return n;
    endfunction

    // run one command; poke >= 0 pulses start again that many cycles into the run
    task automatic run_cmd(input logic o, input logic [15:0] b, input logic [4:0] c,
                           input logic [4:0] i, input logic [31:0] m, input int poke,
                           output logic [1:0] e, output int dones);
        int t = 0;
        bit seen = 0;
        dones = 0;
        e = 2'b11;
        @(negedge clk);
        on = o; base = b; chan = c; irq = i; mval = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk_eq("R9 busy after start", busy, 1);
        while (t < 5000 && !seen) begin
            if (t == poke) begin
                start = 1'b1; on = ~o;
            end else begin
                start = 1'b0; on = o;
            end
            if (done) begin
                seen = 1; dones++; e = err;
            end
            @(negedge clk);
            t++;
        end
        start = 1'b0; on = o;
        if (!seen) chk(0, "watchdog: no done", t, 0);
        if (done) dones++;
    endtask

    task automatic t_reset();
        chk_eq("R1 busy after reset", busy, 0);
        chk_eq("R1 done after reset", done, 0);
        chk_eq("R1 req after reset", bus_req, 0);
    endtask

    task automatic t_on_basic();
        logic [1:0] e; int d; int w0 = nw;
        logic [31:0] imr0 = imr, ier0 = ier;
        cfg_rdy = 0; cfg_word = 32'h2; cfg_errs = 0; cfg_cmp = 2;
        run_cmd(1'b1, 16'h0040, 5'd3, 5'd7, 32'h5A, -1, e, d);
        chk_eq("R7 err ok", e, 0);
        chk_eq("R9 single done", d, 1);
        chk_eq("R7 completion reads", c_isr, 3);
        chk_eq("R2 write count", nw - w0, 7);
        chk_eq("R2 mask set addr", wl_a[w0 % 256], MADDR);
        chk_eq("R2 mask set data", wl_d[w0 % 256], 32'h5A);
        chk_eq("R3 imr data", wl_d[(w0+1) % 256], imr0 | 32'h80);
        chk_eq("R3 imr addr", wl_a[(w0+1) % 256], 16'h10);
        chk_eq("R3 ier data", wl_d[(w0+2) % 256], ier0 | 32'h80);
        chk_eq("R3 ier addr", wl_a[(w0+2) % 256], 16'h0C);
        chk_eq("R3 clear pre", wl_d[(w0+3) % 256], 32'h80);
        chk_eq("R5 resume addr", wl_a[(w0+4) % 256], 16'h004C);
        chk_eq("R5 resume data", wl_d[(w0+4) % 256], 32'h8);
        chk_eq("R7 clear post addr", wl_a[(w0+5) % 256], 16'h08);
        chk_eq("R2 mask release addr", wl_a[(w0+6) % 256], MADDR);
        chk_eq("R2 mask release data", wl_d[(w0+6) % 256], 0);
        repeat (3) @(negedge clk);
        chk_eq("R1 idle after done", busy, 0);
    endtask

    task automatic t_off_nomask();
        logic [1:0] e; int d; int w0 = nw;
        cfg_rdy = 2; cfg_word = 32'h1; cfg_errs = 0; cfg_cmp = 0;
        run_cmd(1'b0, 16'h00C0, 5'd31, 5'd0, 32'h0, -1, e, d);
        chk_eq("R4 err ok", e, 0);
        chk_eq("R4 status reads", c_stat, 3);
        chk_eq("R5 shutoff addr", wl_a[(w0+3) % 256], 16'h00C4);
        chk_eq("R5 shutoff data", wl_d[(w0+3) % 256], 32'h8000_0000);
        chk_eq("R2 no mask access", count_to(w0, MADDR), 0);
        chk(min_gap >= DLY, "R8 poll spacing", min_gap, DLY);
    endtask

    task automatic t_not_ready();
        logic [1:0] e; int d; int w0 = nw;
        cfg_rdy = 0; cfg_word = 32'h1; cfg_errs = 0; cfg_cmp = 0;
        run_cmd(1'b1, 16'h0040, 5'd2, 5'd4, 32'h3, -1, e, d);
        chk_eq("R4 err not ready", e, 1);
        chk_eq("R4 status reads", c_stat, RDY);
        chk_eq("R4 no submit", count_to(w0, 16'h004C), 0);
        chk_eq("R2 last write mask", wl_a[(nw-1) % 256], MADDR);
        chk_eq("R2 last write zero", wl_d[(nw-1) % 256], 0);
        chk(min_gap >= DLY, "R8 poll spacing", min_gap, DLY);
    endtask

    task automatic t_retry_ok();
        logic [1:0] e; int d; int w0 = nw;
        cfg_rdy = 0; cfg_word = 32'h2; cfg_errs = 2; cfg_cmp = 0;
        run_cmd(1'b1, 16'h0040, 5'd6, 5'd9, 32'h0, -1, e, d);
        chk_eq("R6 err ok", e, 0);
        chk_eq("R6 submits", count_to(w0, 16'h004C), 3);
        chk_eq("R6 ready polls", c_stat, 3);
        chk_eq("R7 clears", count_to(w0, 16'h0008), 2);
    endtask

    task automatic t_retry_fail();
        logic [1:0] e; int d; int w0 = nw;
        cfg_rdy = 0; cfg_word = 32'h1; cfg_errs = 99; cfg_cmp = 0;
        run_cmd(1'b0, 16'h0040, 5'd1, 5'd5, 32'hF0, -1, e, d);
        chk_eq("R6 err io", e, 2);
        chk_eq("R6 submits", count_to(w0, 16'h0044), RTR);
        chk_eq("R6 no completion poll", c_isr, 0);
        chk_eq("R6 single clear", count_to(w0, 16'h0008), 1);
        chk_eq("R2 last write mask", wl_a[(nw-1) % 256], MADDR);
        chk_eq("R2 last write zero", wl_d[(nw-1) % 256], 0);
    endtask

    task automatic t_cmp_timeout();
        logic [1:0] e; int d; int w0 = nw;
        cfg_rdy = 0; cfg_word = 32'h2; cfg_errs = 0; cfg_cmp = 999;
        run_cmd(1'b1, 16'h00C0, 5'd0, 5'd31, 32'h1, -1, e, d);
        chk_eq("R7 err io", e, 2);
        chk_eq("R7 completion reads", c_isr, CMP);
        chk_eq("R7 clear after timeout addr", wl_a[(nw-2) % 256], 16'h0008);
        chk_eq("R7 clear after timeout data", wl_d[(nw-2) % 256], 32'h8000_0000);
        chk_eq("R2 last write zero", wl_d[(nw-1) % 256], 0);
        chk(min_gap >= 0, "R8 no status poll gap", min_gap, 0);
        chk_eq("R7 write count", nw - w0, 7);
    endtask

    task automatic t_busy_ignore();
        logic [1:0] e; int d; int w0 = nw; int wend;
        cfg_rdy = 1; cfg_word = 32'h2; cfg_errs = 0; cfg_cmp = 1;
        run_cmd(1'b1, 16'h0040, 5'd4, 5'd2, 32'h0, 6, e, d);
        chk_eq("R9 err ok", e, 0);
        chk_eq("R9 single done", d, 1);
        chk_eq("R9 no shutoff write", count_to(w0, 16'h0044), 0);
        chk_eq("R9 one resume write", count_to(w0, 16'h004C), 1);
        wend = nw;
        repeat (30) @(negedge clk);
        chk_eq("R9 idle after ignored start", busy, 0);
        chk_eq("R9 no further writes", nw - wend, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_on_basic();
        t_off_nomask();
        t_not_ready();
        t_retry_ok();
        t_retry_fail();
        t_cmp_timeout();
        t_busy_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule